// File: doc/BRIEF.md
# Dual-Direction FIFO Status Controller

This block joins a host-bus side to a local add-on side through two independent 32-bit queues. The inbound queue carries words from the host to the local side. The outbound queue carries words from the local side to the host, and it ends in a single staging register that the host pops from. The local side sees an empty flag on the inbound queue and a full flag on the outbound queue. Two extra status flags sit beside them: one reports that the inbound queue is full, and the other reports that the outbound queue has emptied into the staging register.

The local read port is show-ahead. The head word is always present on the read bus. Each clock edge with the active-low read strobe low consumes one word, so holding the strobe low streams one word per clock. Each queue has its own active-low synchronous clear. Two active-high enables gate the requests to master the host bus. Reads are requested while the inbound queue has room. Writes are requested while the outbound path holds data.

Top module: `bidir_fifo_ctrl`

## Requirements
- R1: Words pushed on the host side leave the local read port in push order. The head word is on `locRdData` before the edge that consumes it. Each edge with `locRdN` low and the inbound queue not empty consumes exactly one word.
- R2: `locRdEmpty` is 1 exactly when the inbound queue holds zero words. It shows the new state in the cycle after each push, pop or clear edge.
- R3: `h2lFull` is 1 exactly when the inbound queue holds DEPTH (default 8) words. A host push while it is full is dropped, and the stored words are unchanged.
- R4: A local read on an empty inbound queue, or a host pop while `hostPopValid` is 0, is ignored. No pointer or content changes.
- R5: Outbound words reach `hostPopData` in write order. A word written into an empty outbound path appears with `hostPopValid`=1 after the second clock edge. The staging word holds while `hostPop` is low. Each edge with `hostPop` high and the path not empty delivers the next word.
- R6: `locWrFull` is 1 exactly when the outbound queue, not counting the staging register, holds DEPTH words. A local write while it is full is dropped, so the path holds at most DEPTH+1 words.
- R7: `l2hDrained` is 1 exactly when the outbound queue holds zero words. The staging register may still hold the last word.
- R8: `h2lClrN` low at an edge empties the inbound queue. It overrides a host push or local read in the same cycle and leaves the outbound path untouched.
- R9: `l2hClrN` low at an edge empties the outbound queue and the staging register. It overrides a local write or host pop in the same cycle and leaves the inbound queue untouched.
- R10: `mstWrReq` equals `mstWrEn` AND (outbound queue not empty OR `hostPopValid`).
- R11: `mstRdReq` equals `mstRdEn` AND NOT `h2lFull`.
- R12: After reset, `locRdEmpty`=1, `h2lFull`=0, `locWrFull`=0, `l2hDrained`=1 and `hostPopValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostPush | input | 1 | Push hostPushData into the inbound queue |
| hostPushData | input | 32 | Host word for the inbound queue |
| hostPop | input | 1 | Consume the staging word |
| hostPopData | output | 32 | Staging word for the host |
| hostPopValid | output | 1 | Staging register holds a word |
| locRdN | input | 1 | Active-low local read strobe |
| locRdData | output | 32 | Head word of the inbound queue |
| locRdEmpty | output | 1 | Inbound queue empty |
| locWr | input | 1 | Write locWrData into the outbound queue |
| locWrData | input | 32 | Local word for the outbound queue |
| locWrFull | output | 1 | Outbound queue full |
| h2lFull | output | 1 | Inbound queue full (extra flag) |
| l2hDrained | output | 1 | Outbound queue emptied into staging (extra flag) |
| h2lClrN | input | 1 | Active-low clear of the inbound queue |
| l2hClrN | input | 1 | Active-low clear of the outbound path |
| mstWrEn | input | 1 | Enable for host-bus master write requests |
| mstRdEn | input | 1 | Enable for host-bus master read requests |
| mstWrReq | output | 1 | Host-bus master write request |
| mstRdReq | output | 1 | Host-bus master read request |

## Verification
Every flag comes from occupancy counters that update on the edge that accepts a push, pop or clear. The flags, and the requests built from them, are therefore due in the cycle right after that edge. A local write reaches the staging register one edge later, so it is visible to the host two edges after it is written. Read data is show-ahead: it is due before the consuming edge and is checked then. The bench drives inputs just after a falling edge and samples just after the next falling edge, so each check lands in the first cycle its result is due. Sweeps over every fill level from empty to one past capacity compare flags and data with values worked out arithmetically from the fill level.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  // Strobes from control to datapath, already gated by flags and clears.
  typedef struct packed {
    logic h2lPush;
    logic h2lPop;
    logic h2lClr;
    logic l2hPush;
    logic l2hMove;   // outbound queue head into staging register
    logic l2hUnload; // staging consumed with nothing to replace it
    logic l2hClr;
  } bfc_strobe_t;
endpackage

// File: rtl/bfc_ring.sv
module bfc_ring #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count != FULL_CNT || pop));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
endmodule

// File: rtl/bfc_datapath.sv
module bfc_datapath
  import bfc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bfc_strobe_t      strb,
  input  logic [WIDTH-1:0] hostPushData,
  input  logic [WIDTH-1:0] locWrData,
  output logic [WIDTH-1:0] locRdData,
  output logic [WIDTH-1:0] hostPopData,
  output logic             stageValid,
  output logic [CNT_W-1:0] h2lCnt,
  output logic [CNT_W-1:0] l2hCnt
);
  logic [WIDTH-1:0] l2hHead;
  logic [WIDTH-1:0] stageData;

  bfc_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH)) inboundQ (
    .clk(clk), .rstN(rstN), .clr(strb.h2lClr), .push(strb.h2lPush),
    .pop(strb.h2lPop), .wrData(hostPushData), .headData(locRdData),
    .count(h2lCnt)
  );

  bfc_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH)) outboundQ (
    .clk(clk), .rstN(rstN), .clr(strb.l2hClr), .push(strb.l2hPush),
    .pop(strb.l2hMove), .wrData(locWrData), .headData(l2hHead),
    .count(l2hCnt)
  );

  // Final output buffer on the host side of the outbound queue.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      stageData  <= '0;
    end else if (strb.l2hClr) begin
      stageValid <= 1'b0;
    end else if (strb.l2hMove) begin
      stageValid <= 1'b1;
      stageData  <= l2hHead;
    end else if (strb.l2hUnload) begin
      stageValid <= 1'b0;
    end
  end

  assign hostPopData = stageData;

  assert_stage_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stageValid && !strb.l2hMove && !strb.l2hUnload && !strb.l2hClr)
      |=> (stageValid && $stable(stageData)));
  assert_stage_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.l2hClr |=> !stageValid);
endmodule

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
  import bfc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostPush,
  input  logic             hostPop,
  input  logic             locRdN,
  input  logic             locWr,
  input  logic             h2lClrN,
  input  logic             l2hClrN,
  input  logic             mstWrEn,
  input  logic             mstRdEn,
  input  logic [CNT_W-1:0] h2lCnt,
  input  logic [CNT_W-1:0] l2hCnt,
  input  logic             stageValid,
  output bfc_strobe_t      strb,
  output logic             locRdEmpty,
  output logic             locWrFull,
  output logic             h2lFull,
  output logic             l2hDrained,
  output logic             mstWrReq,
  output logic             mstRdReq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic h2lAny, l2hAny;

  assign h2lAny     = (h2lCnt != '0);
  assign l2hAny     = (l2hCnt != '0);
  assign locRdEmpty = !h2lAny;
  assign h2lFull    = (h2lCnt == FULL_CNT);
  assign locWrFull  = (l2hCnt == FULL_CNT);
  assign l2hDrained = !l2hAny;

  always_comb begin
    strb.h2lClr    = !h2lClrN;
    strb.h2lPush   = h2lClrN && hostPush && !h2lFull;
    strb.h2lPop    = h2lClrN && !locRdN && h2lAny;
    strb.l2hClr    = !l2hClrN;
    strb.l2hPush   = l2hClrN && locWr && !locWrFull;
    strb.l2hMove   = l2hClrN && l2hAny && (!stageValid || hostPop);
    strb.l2hUnload = l2hClrN && !l2hAny && stageValid && hostPop;
  end

  assign mstWrReq = mstWrEn && (l2hAny || stageValid);
  assign mstRdReq = mstRdEn && !h2lFull;

  assert_full_blocks_push_R3: assert property (@(posedge clk) disable iff (!rstN)
    (h2lFull && h2lClrN && locRdN) |=> h2lFull);
  assert_empty_read_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!h2lAny && !hostPush) |=> !h2lAny);
  assert_clear_inbound_R8: assert property (@(posedge clk) disable iff (!rstN)
    !h2lClrN |=> (h2lCnt == '0));
  assert_clear_outbound_R9: assert property (@(posedge clk) disable iff (!rstN)
    !l2hClrN |=> (l2hCnt == '0));
  assert_read_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (h2lClrN && !locRdN && h2lAny && !hostPush) |=> (h2lCnt == $past(h2lCnt) - CNT_W'(1)));
endmodule

// File: rtl/bidir_fifo_ctrl.sv
module bidir_fifo_ctrl
  import bfc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostPush,
  input  logic [WIDTH-1:0] hostPushData,
  input  logic             hostPop,
  output logic [WIDTH-1:0] hostPopData,
  output logic             hostPopValid,
  input  logic             locRdN,
  output logic [WIDTH-1:0] locRdData,
  output logic             locRdEmpty,
  input  logic             locWr,
  input  logic [WIDTH-1:0] locWrData,
  output logic             locWrFull,
  output logic             h2lFull,
  output logic             l2hDrained,
  input  logic             h2lClrN,
  input  logic             l2hClrN,
  input  logic             mstWrEn,
  input  logic             mstRdEn,
  output logic             mstWrReq,
  output logic             mstRdReq
);
  bfc_strobe_t      strb;
  logic [CNT_W-1:0] h2lCnt, l2hCnt;
  logic             stageValid;

  bfc_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .hostPush(hostPush), .hostPop(hostPop),
    .locRdN(locRdN), .locWr(locWr), .h2lClrN(h2lClrN), .l2hClrN(l2hClrN),
    .mstWrEn(mstWrEn), .mstRdEn(mstRdEn), .h2lCnt(h2lCnt), .l2hCnt(l2hCnt),
    .stageValid(stageValid), .strb(strb), .locRdEmpty(locRdEmpty),
    .locWrFull(locWrFull), .h2lFull(h2lFull), .l2hDrained(l2hDrained),
    .mstWrReq(mstWrReq), .mstRdReq(mstRdReq)
  );

  bfc_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hostPushData(hostPushData),
    .locWrData(locWrData), .locRdData(locRdData), .hostPopData(hostPopData),
    .stageValid(stageValid), .h2lCnt(h2lCnt), .l2hCnt(l2hCnt)
  );

  assign hostPopValid = stageValid;
endmodule

// File: tb/bidir_fifo_ctrl_test.sv
module bidir_fifo_ctrl_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostPush = 1'b0, hostPop = 1'b0, locRdN = 1'b1, locWr = 1'b0;
  logic [31:0] hostPushData = '0, locWrData = '0;
  logic        h2lClrN = 1'b1, l2hClrN = 1'b1, mstWrEn = 1'b0, mstRdEn = 1'b0;
  logic [31:0] hostPopData, locRdData;
  logic        hostPopValid, locRdEmpty, locWrFull, h2lFull, l2hDrained;
  logic        mstWrReq, mstRdReq;

  int checks = 0;
  int fails  = 0;

  bidir_fifo_ctrl uut (
    .clk(clk), .rstN(rstN), .hostPush(hostPush), .hostPushData(hostPushData),
    .hostPop(hostPop), .hostPopData(hostPopData), .hostPopValid(hostPopValid),
    .locRdN(locRdN), .locRdData(locRdData), .locRdEmpty(locRdEmpty),
    .locWr(locWr), .locWrData(locWrData), .locWrFull(locWrFull),
    .h2lFull(h2lFull), .l2hDrained(l2hDrained), .h2lClrN(h2lClrN),
    .l2hClrN(l2hClrN), .mstWrEn(mstWrEn), .mstRdEn(mstRdEn),
    .mstWrReq(mstWrReq), .mstRdReq(mstRdReq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] inWord(input int n, input int i);
    return 32'hA000_0000 + 32'(n * 16 + i);
  endfunction

  function automatic logic [31:0] outWord(input int n, input int i);
    return 32'hB000_0000 + 32'(n * 256 + i);
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    // R12 reset state
    chk("R12 locRdEmpty", 32'(locRdEmpty), 32'd1);
    chk("R12 h2lFull", 32'(h2lFull), 32'd0);
    chk("R12 locWrFull", 32'(locWrFull), 32'd0);
    chk("R12 l2hDrained", 32'(l2hDrained), 32'd1);
    chk("R12 hostPopValid", 32'(hostPopValid), 32'd0);

    // Inbound sweep over every fill level, one past capacity included
    mstRdEn = 1'b1;
    for (int n = 0; n <= DEPTH + 1; n++) begin
      int m;
      m = (n > DEPTH) ? DEPTH : n;
      h2lClrN = 1'b0; step(); h2lClrN = 1'b1;
      for (int i = 0; i < n; i++) begin
        hostPush = 1'b1; hostPushData = inWord(n, i); step();
      end
      hostPush = 1'b0;
      chk("R3 h2lFull after fill", 32'(h2lFull), 32'(m == DEPTH));
      chk("R2 locRdEmpty after fill", 32'(locRdEmpty), 32'(m == 0));
      chk("R11 mstRdReq enabled", 32'(mstRdReq), 32'(m != DEPTH));
      for (int i = 0; i < m; i++) begin
        chk("R1 burst data", locRdData, inWord(n, i));
        locRdN = 1'b0; step();
        chk("R2 empty after read", 32'(locRdEmpty), 32'(i == m - 1));
      end
      step(); // read on empty queue
      locRdN = 1'b1;
      hostPush = 1'b1; hostPushData = 32'hC0DE_0000 + 32'(n); step();
      hostPush = 1'b0;
      chk("R4 empty read ignored", locRdData, 32'hC0DE_0000 + 32'(n));
      chk("R2 one word not empty", 32'(locRdEmpty), 32'd0);
    end

    // R11 request disabled while inbound not full
    mstRdEn = 1'b0; step();
    chk("R11 mstRdReq disabled", 32'(mstRdReq), 32'd0);

    // Outbound latency: single word into empty path
    h2lClrN = 1'b0; l2hClrN = 1'b0; step(); h2lClrN = 1'b1; l2hClrN = 1'b1;
    locWr = 1'b1; locWrData = 32'h1234_5678; step(); locWr = 1'b0;
    chk("R5 not yet staged", 32'(hostPopValid), 32'd0);
    chk("R7 queue holds word", 32'(l2hDrained), 32'd0);
    step();
    chk("R5 staged after two edges", 32'(hostPopValid), 32'd1);
    chk("R5 staged data", hostPopData, 32'h1234_5678);
    chk("R7 drained with staged word", 32'(l2hDrained), 32'd1);
    step(); step();
    chk("R5 staging holds", hostPopData, 32'h1234_5678);

    // Outbound sweep over every fill level
    mstWrEn = 1'b1;
    for (int n = 0; n <= DEPTH + 2; n++) begin
      int m;
      m = (n > DEPTH + 1) ? DEPTH + 1 : n;
      l2hClrN = 1'b0; step(); l2hClrN = 1'b1;
      for (int i = 0; i < n; i++) begin
        locWr = 1'b1; locWrData = outWord(n, i); step();
      end
      locWr = 1'b0;
      step();
      chk("R6 locWrFull after fill", 32'(locWrFull), 32'(n >= DEPTH + 1));
      chk("R7 l2hDrained after fill", 32'(l2hDrained), 32'(n <= 1));
      chk("R5 valid after fill", 32'(hostPopValid), 32'(n > 0));
      chk("R10 mstWrReq with data", 32'(mstWrReq), 32'(n > 0));
      for (int i = 0; i < m; i++) begin
        chk("R5 pop valid", 32'(hostPopValid), 32'd1);
        chk("R5 pop order", hostPopData, outWord(n, i));
        hostPop = 1'b1; step();
      end
      hostPop = 1'b0;
      chk("R5 empty after pops", 32'(hostPopValid), 32'd0);
      chk("R7 drained after pops", 32'(l2hDrained), 32'd1);
      chk("R10 mstWrReq no data", 32'(mstWrReq), 32'd0);
      hostPop = 1'b1; step(); hostPop = 1'b0; // pop with nothing staged
      locWr = 1'b1; locWrData = 32'hD00D_0000 + 32'(n); step(); locWr = 1'b0;
      step();
      chk("R4 empty pop ignored", hostPopData, 32'hD00D_0000 + 32'(n));
    end

    // R10 disabled enable blocks request even with data
    mstWrEn = 1'b0; step();
    chk("R10 mstWrReq disabled", 32'(mstWrReq), 32'd0);

    // R8 inbound clear beats push, outbound untouched
    l2hClrN = 1'b0; step(); l2hClrN = 1'b1;
    locWr = 1'b1; locWrData = 32'hEEEE_0001; step(); locWr = 1'b0; step();
    for (int i = 0; i < 3; i++) begin
      hostPush = 1'b1; hostPushData = inWord(99, i); step();
    end
    h2lClrN = 1'b0; hostPushData = 32'hBAD0_0000; locRdN = 1'b0; step();
    h2lClrN = 1'b1; hostPush = 1'b0; locRdN = 1'b1;
    chk("R8 inbound emptied", 32'(locRdEmpty), 32'd1);
    chk("R8 outbound kept valid", 32'(hostPopValid), 32'd1);
    chk("R8 outbound kept data", hostPopData, 32'hEEEE_0001);

    // R9 outbound clear beats write and pop, inbound untouched
    hostPush = 1'b1; hostPushData = 32'h7777_0001; step(); hostPush = 1'b0;
    for (int i = 0; i < 3; i++) begin
      locWr = 1'b1; locWrData = outWord(77, i); step();
    end
    l2hClrN = 1'b0; hostPop = 1'b1; step();
    l2hClrN = 1'b1; locWr = 1'b0; hostPop = 1'b0;
    mstWrEn = 1'b1;
    chk("R9 staging cleared", 32'(hostPopValid), 32'd0);
    chk("R9 queue cleared", 32'(l2hDrained), 32'd1);
    chk("R9 not full", 32'(locWrFull), 32'd0);
    step();
    chk("R9 no write request", 32'(mstWrReq), 32'd0);
    chk("R9 inbound kept", locRdData, 32'h7777_0001);
    chk("R9 inbound not empty", 32'(locRdEmpty), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule